// File: doc/BRIEF.md
# Byte-Level GPIO Expander Register Bank

This block is the register side of an 8-bit general-purpose I/O expander that sits behind an I2C target. A separate front end handles the bit-level bus signalling. It passes this block decoded events: an address match with its direction, received bytes flagged as the first byte of a write, read-byte requests, and stop. The first byte of a write transaction is a command byte. Its two low bits load a register pointer. Any further bytes in the same write go to the register that the pointer selects. Every read returns the selected register, and the pointer stays where it is until a later write brings a new command byte.

The bank holds four registers: the sampled pin inputs, the output values, a polarity mask applied to input reads, and a direction register. A direction bit of 1 makes its pin an input with the driver off. A direction bit of 0 drives the matching output bit onto the pin. Pin inputs pass through a two-flop synchroniser before they reach the read path.

Top module: `gpio_expander_regs`

## Requirements
- R1: A synchronous active-high reset sets the output register to all ones, polarity to all zeros, direction to all ones (so `pin_oe` is all zeros and `pin_out` all ones), and the pointer to 0.
- R2: A command byte loads the pointer from bits [1:0] as follows: 0 selects the input register, 1 output, 2 polarity and 3 direction. Bits [7:2] have no effect.
- R3: Data bytes that follow the command byte in the same write transaction all go to the selected register, and the last one wins. The pointer does not advance, so the other registers keep their values.
- R4: The input register is read-only. A data byte written while the pointer is 0 changes no register.
- R5: Read transactions never load the pointer. Successive reads, across separate read transactions, return the register chosen by the last command byte.
- R6: A read of the input register returns the synchronised pins XOR the polarity register. A pin change is visible to a read requested two cycles after the change.
- R7: `pin_oe[i]` equals the inverse of direction bit i, and `pin_out` equals the output register.
- R8: `rd_valid` is high exactly in the cycle after a `rd_req` cycle, with `rd_data` valid alongside it.
- R9: Bytes received outside an open write transaction have no effect on the pointer or on any register. This covers bytes before any write address match, bytes after stop, and bytes in a read transaction. A data byte in a write that has not yet carried a command byte is also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_hit | input | 1 | Address matched; opens a transaction |
| addr_rd | input | 1 | Direction of the matched address, 1 = read |
| wr_valid | input | 1 | A byte was received this cycle |
| wr_first | input | 1 | The received byte is the first of a write transaction |
| wr_byte | input | DATA_W | Received byte |
| rd_req | input | 1 | Front end requests a byte to transmit |
| stop | input | 1 | Stop condition seen; closes the transaction |
| rd_data | output | DATA_W | Byte to transmit |
| rd_valid | output | 1 | `rd_data` is valid |
| pin_in | input | DATA_W | Raw pin levels |
| pin_oe | output | DATA_W | Per-pin output enable, 1 = driven |
| pin_out | output | DATA_W | Per-pin output value |

## Verification
A seeded random mix of write transactions, read transactions, pin changes and stray bytes is run against a bench-side register model. Each write transaction uses a random command byte with random upper bits and one to three data bytes, so a wrong pointer field or any auto-increment shows up as a miscompare. Directed cases cover the reset state, writes aimed at the read-only input register, and reads repeated across transactions with no command in between, which separates a sticky pointer from one that resets. Other directed cases send bytes after stop, bytes inside a read transaction, and a data byte that arrives before any command. Pin changes followed by input reads under a non-zero polarity mask check the XOR and the two-cycle synchroniser latency.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  typedef enum logic [1:0] {
    SEL_INPUT    = 2'd0,
    SEL_OUTPUT   = 2'd1,
    SEL_POLARITY = 2'd2,
    SEL_DIR      = 2'd3
  } sel_e;

  localparam int SEL_W = 2;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpx_xfer_ctrl.sv
module gpx_xfer_ctrl
  import gpx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_hit,
  input  logic              addr_rd,
  input  logic              wr_valid,
  input  logic              wr_first,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              stop,
  output sel_e              sel_ptr,
  output logic              reg_we,
  output logic              cmd_load
);
  logic in_write;
  logic cmd_seen;

  // A byte counts only while a write transaction is open.
  assign cmd_load = wr_valid && wr_first && in_write;
  assign reg_we   = wr_valid && !wr_first && in_write && cmd_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_write <= 1'b0;
      cmd_seen <= 1'b0;
    end else if (addr_hit) begin
      in_write <= !addr_rd;
      cmd_seen <= 1'b0;
    end else if (stop) begin
      in_write <= 1'b0;
      cmd_seen <= 1'b0;
    end else if (cmd_load) begin
      cmd_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           sel_ptr <= SEL_INPUT;
    else if (cmd_load) sel_ptr <= sel_e'(wr_byte[SEL_W-1:0]);
  end
endmodule

// File: rtl/gpx_reg_bank.sv
module gpx_reg_bank
  import gpx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  sel_e              sel_ptr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pin_sync,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] out_q,
  output logic [DATA_W-1:0] dir_q
);
  localparam logic [DATA_W-1:0] OUT_RST = '1;
  localparam logic [DATA_W-1:0] POL_RST = '0;
  localparam logic [DATA_W-1:0] DIR_RST = '1;

  logic [DATA_W-1:0] pol_q;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= OUT_RST;
      pol_q <= POL_RST;
      dir_q <= DIR_RST;
    end else if (reg_we) begin
      case (sel_ptr)
        SEL_OUTPUT:   out_q <= wdata;
        SEL_POLARITY: pol_q <= wdata;
        SEL_DIR:      dir_q <= wdata;
        default:      ;
      endcase
    end
  end

  always_comb begin
    case (sel_ptr)
      SEL_INPUT:    rd_mux = pin_sync ^ pol_q;
      SEL_OUTPUT:   rd_mux = out_q;
      SEL_POLARITY: rd_mux = pol_q;
      default:      rd_mux = dir_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_expander_regs.sv
module gpio_expander_regs
  import gpx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_hit,
  input  logic              addr_rd,
  input  logic              wr_valid,
  input  logic              wr_first,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_req,
  input  logic              stop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_oe,
  output logic [DATA_W-1:0] pin_out
);
  sel_e              sel_ptr;
  logic              reg_we;
  logic              cmd_load;
  logic [DATA_W-1:0] pin_sync;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] dir_q;

  gpx_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gpx_xfer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .addr_hit (addr_hit),
    .addr_rd  (addr_rd),
    .wr_valid (wr_valid),
    .wr_first (wr_first),
    .wr_byte  (wr_byte),
    .stop     (stop),
    .sel_ptr  (sel_ptr),
    .reg_we   (reg_we),
    .cmd_load (cmd_load)
  );

  gpx_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .sel_ptr  (sel_ptr),
    .wdata    (wr_byte),
    .pin_sync (pin_sync),
    .rd_req   (rd_req),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .out_q    (out_q),
    .dir_q    (dir_q)
  );

  assign pin_oe  = ~dir_q;
  assign pin_out = out_q;
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_first,
  input logic [DATA_W-1:0] wr_byte,
  input logic              rd_req,
  input logic              rd_valid,
  input logic              cmd_load,
  input logic              reg_we,
  input logic [1:0]        sel_ptr,
  input logic [DATA_W-1:0] pin_oe,
  input logic [DATA_W-1:0] pin_out
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && pin_out == '1 && sel_ptr == 2'd0));

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_load |=> sel_ptr == $past(wr_byte[1:0]));

  // R5
  ptr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_load |=> $stable(sel_ptr));

  // R8
  rdv_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  // R8
  rdv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);

  // R9
  pins_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!reg_we && !$past(rst)) |=> ($stable(pin_oe) && $stable(pin_out)));

  // R9
  no_write_without_byte_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |-> (!reg_we && !cmd_load));
endmodule

bind gpio_expander_regs gpx_checker #(.DATA_W(DATA_W)) u_gpx_checker (
  .clk      (clk),
  .rst      (rst),
  .wr_valid (wr_valid),
  .wr_first (wr_first),
  .wr_byte  (wr_byte),
  .rd_req   (rd_req),
  .rd_valid (rd_valid),
  .cmd_load (cmd_load),
  .reg_we   (reg_we),
  .sel_ptr  (sel_ptr),
  .pin_oe   (pin_oe),
  .pin_out  (pin_out)
);

// File: tb/test_gpio_expander_regs.sv
module test_gpio_expander_regs;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         addr_hit = 1'b0, addr_rd = 1'b0;
  logic         wr_valid = 1'b0, wr_first = 1'b0;
  logic [W-1:0] wr_byte = '0;
  logic         rd_req = 1'b0, stop = 1'b0;
  logic [W-1:0] rd_data, pin_oe, pin_out;
  logic         rd_valid;
  logic [W-1:0] pin_in = '0;

  logic [W-1:0] m_out, m_pol, m_dir;
  logic [1:0]   m_ptr;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_expander_regs #(.DATA_W(W)) i_gpio_expander_regs (
    .clk(clk), .rst(rst), .addr_hit(addr_hit), .addr_rd(addr_rd),
    .wr_valid(wr_valid), .wr_first(wr_first), .wr_byte(wr_byte),
    .rd_req(rd_req), .stop(stop), .rd_data(rd_data), .rd_valid(rd_valid),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_reset();
    m_out = '1; m_pol = '0; m_dir = '1; m_ptr = 2'd0;
  endtask

  function automatic logic [W-1:0] model_read();
    case (m_ptr)
      2'd0:    return pin_in ^ m_pol;
      2'd1:    return m_out;
      2'd2:    return m_pol;
      default: return m_dir;
    endcase
  endfunction

  task automatic open_tx(input bit rd);
    addr_hit = 1'b1; addr_rd = rd; cyc(); addr_hit = 1'b0; addr_rd = 1'b0;
  endtask

  task automatic close_tx();
    stop = 1'b1; cyc(); stop = 1'b0;
  endtask

  task automatic put_byte(input logic [W-1:0] b, input bit first);
    wr_valid = 1'b1; wr_first = first; wr_byte = b; cyc();
    wr_valid = 1'b0; wr_first = 1'b0; wr_byte = '0;
  endtask

  // Full write: command then n data bytes; model updated from the requirements.
  task automatic write_tx(input logic [W-1:0] cmd, input int n, input logic [W-1:0] d0,
                          input logic [W-1:0] d1, input logic [W-1:0] d2);
    open_tx(1'b0);
    put_byte(cmd, 1'b1);
    m_ptr = cmd[1:0];
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] d;
      d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
      put_byte(d, 1'b0);
      case (m_ptr)
        2'd1: m_out = d;
        2'd2: m_pol = d;
        2'd3: m_dir = d;
        default: ;
      endcase
    end
    close_tx();
  endtask

  task automatic read_one(input string tag);
    logic [W-1:0] exp;
    exp = model_read();
    rd_req = 1'b1; cyc(); rd_req = 1'b0;
    chk(rd_valid === 1'b1, "R8 rd_valid high after request", {7'd0, rd_valid}, 8'h01);
    chk(rd_data === exp, tag, rd_data, exp);
    cyc();
    chk(rd_valid === 1'b0, "R8 rd_valid single pulse", {7'd0, rd_valid}, 8'h00);
  endtask

  task automatic read_tx(input int n, input string tag);
    open_tx(1'b1);
    for (int i = 0; i < n; i++) read_one(tag);
    close_tx();
  endtask

  task automatic check_pins(input string tag);
    chk(pin_oe === ~m_dir, {tag, " R7 pin_oe"}, pin_oe, ~m_dir);
    chk(pin_out === m_out, {tag, " R7 pin_out"}, pin_out, m_out);
  endtask

  task automatic set_pins(input logic [W-1:0] v);
    pin_in = v; cyc(); cyc();
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(); cyc(); rst = 1'b0; model_reset();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    model_reset();
    @(negedge clk);
    pin_in = 8'hA5;
    do_reset();
    cyc();
    // R1 reset state
    chk(pin_oe === 8'h00, "R1 reset pin_oe", pin_oe, 8'h00);
    chk(pin_out === 8'hFF, "R1 reset pin_out", pin_out, 8'hFF);
    read_tx(1, "R1 R6 reset pointer reads input");

    // R3 R7 output write
    write_tx(8'h01, 1, 8'h3C, 8'h00, 8'h00);
    check_pins("R3 output write");
    // R2 upper command bits ignored, polarity selected
    write_tx(8'hFE, 1, 8'h0F, 8'h00, 8'h00);
    read_tx(1, "R2 upper bits ignored");
    // R6 input XOR polarity, with pin change
    set_pins(8'h96);
    write_tx(8'h00, 0, 8'h00, 8'h00, 8'h00);
    read_tx(1, "R6 input xor polarity");
    // R3 no auto-increment, last byte wins
    write_tx(8'h03, 2, 8'h11, 8'h22, 8'h00);
    check_pins("R3 repeated bytes");
    read_tx(1, "R3 last byte wins");
    // R4 write to input register ignored
    write_tx(8'hFC, 2, 8'h55, 8'hAA, 8'h00);
    check_pins("R4 input read-only");
    read_tx(1, "R4 input still pins xor polarity");
    write_tx(8'h02, 0, 8'h00, 8'h00, 8'h00);
    read_tx(1, "R4 polarity unchanged");
    // R5 sticky pointer across reads
    write_tx(8'h01, 0, 8'h00, 8'h00, 8'h00);
    read_tx(2, "R5 sticky pointer first");
    read_tx(3, "R5 sticky pointer later");
    // R9 stray bytes
    put_byte(8'h03, 1'b1);
    put_byte(8'h00, 1'b0);
    check_pins("R9 bytes after stop");
    open_tx(1'b1);
    put_byte(8'h02, 1'b1);
    put_byte(8'h77, 1'b0);
    read_one("R9 byte in read transaction");
    close_tx();
    open_tx(1'b0);
    put_byte(8'h5A, 1'b0);
    close_tx();
    check_pins("R9 data before command");
    read_tx(1, "R9 pointer kept");
    // R6 latency: change pins and read two cycles later
    write_tx(8'h00, 0, 8'h00, 8'h00, 8'h00);
    open_tx(1'b1);
    pin_in = 8'h3B; cyc(); cyc();
    read_one("R6 two-cycle input latency");
    close_tx();

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 4;
      case (op)
        0: write_tx(W'($urandom), 1 + ($urandom % 3), W'($urandom), W'($urandom), W'($urandom));
        1: read_tx(1 + ($urandom % 3), "R5 R6 random read");
        2: set_pins(W'($urandom));
        default: begin
          put_byte(W'($urandom), 1'($urandom));
        end
      endcase
      check_pins("R7 random");
    end

    // R1 reset after activity
    write_tx(8'h03, 1, 8'h00, 8'h00, 8'h00);
    write_tx(8'h02, 1, 8'hFF, 8'h00, 8'h00);
    do_reset();
    cyc();
    chk(pin_oe === 8'h00, "R1 reset pin_oe again", pin_oe, 8'h00);
    chk(pin_out === 8'hFF, "R1 reset pin_out again", pin_out, 8'hFF);
    read_tx(1, "R1 pointer and polarity cleared");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule